// File: doc/BRIEF.md
# Read vote consensus unit

This block merges a short run of consecutive base-called DNA reads into one consensus read. The reads come from overlapping windows of the same signal, so each read repeats the tail of the one before it. Symbols arrive one per cycle on a load port. A flag marks the last symbol of each read, and a second flag marks the last read of the group. When the group is closed, the unit places each later read against the read before it, one pair per cycle. Every suffix start of the earlier read is a row, and all rows are compared at once against a short probe: the leading bases of the later read.

The earliest row that matches gives the longest overlap. This fixes how far the later read is shifted. No gaps are inserted, because the order of the reads is known. After every read has an offset, the unit walks along the aligned positions and emits one consensus base per cycle. Each base is the majority symbol among the reads that cover that position. A flag marks the final base.

Top module: `rvc_top`

## Requirements
- R1: Symbols are opaque 3-bit codes. All eight values 0 to 7 are legal. Votes compare codes for equality only, and the consensus carries the winning code unchanged.
- R2: While idle, each cycle with `in_valid` high appends `in_sym` to the current read. `in_eor` high on that cycle closes the read. `in_eor` and `in_eog` high together close both the read and the group, and start alignment.
- R3: A later read is placed at the smallest start s in the earlier read, of length Lp, that meets three conditions: the PROBE (3) symbols of the earlier read from s onward equal the first PROBE symbols of the later read; s + PROBE <= Lp; and Lp - s does not exceed the later read's length. The later read's offset is then the earlier read's offset plus s.
- R4: If no start qualifies, the later read is appended directly. Its offset is the earlier read's offset plus Lp.
- R5: The consensus length is the last read's offset plus its length. Bases come one per cycle, with `out_valid` high and uninterrupted, and `out_last` is high with the final base only.
- R6: Each consensus base is the code held by the largest number of the reads that cover that position.
- R7: When two or more codes tie for the largest count, the code of the earliest covering read among them wins.
- R8: A group holds at most 8 reads. Symbols of any further reads in the same group are dropped, and they do not affect that group or the next one.
- R9: A read holds at most 30 symbols. Further symbols before its end flag are dropped.
- R10: Load-port activity during alignment or emission is ignored. After the final base, the output stays idle until a new group has been loaded.
- R11: After reset, `out_valid` and `out_last` are low and the unit waits for a new group.
- R12: A group of a single read emits that read unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load symbol present |
| in_sym | input | 3 | Symbol code |
| in_eor | input | 1 | Last symbol of the current read |
| in_eog | input | 1 | With `in_eor`: last read of the group |
| out_valid | output | 1 | Consensus base present |
| out_sym | output | 3 | Consensus symbol code |
| out_last | output | 1 | Final consensus base of the group |

## Verification
Two things can land in the same cycle: a symbol offered on the load port and the alignment step or a consensus base being emitted. The bench provokes this by driving read and group end flags on every cycle while the unit aligns and emits a group. It judges the result by three observations: the emitted bases still match the model, the output stays idle afterwards, and the following group comes out exactly as the model predicts. Sweeps over read count, stride and injected substitutions exercise overlap placement, majority and tie breaking, with every expected base computed arithmetically from the requirements.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
   localparam int RVC_SYM_W = 3;
   typedef logic [RVC_SYM_W-1:0] rvc_sym_t;
   typedef enum logic [1:0] {ST_LOAD, ST_ALIGN, ST_EMIT} rvc_state_e;
endpackage

// File: rtl/rvc_match.sv
// Parallel row comparator: every suffix start of the earlier read against the probe.
module rvc_match import rvc_pkg::*; #(
   parameter int MAX_LEN = 30,
   parameter int PROBE   = 3,
   parameter int LEN_W   = 5
) (
   input  rvc_sym_t          row_src [MAX_LEN],
   input  rvc_sym_t          probe   [PROBE],
   input  logic [LEN_W-1:0]  plen,
   input  logic [LEN_W-1:0]  clen,
   output logic              hit,
   output logic [LEN_W-1:0]  start
);
   logic [MAX_LEN-1:0] row_hit;

   for (genvar s = 0; s < MAX_LEN; s++) begin : g_row
      if (s + PROBE <= MAX_LEN) begin : g_fit
         logic [PROBE-1:0] eq;
         for (genvar j = 0; j < PROBE; j++) begin : g_sym
            assign eq[j] = (row_src[s+j] == probe[j]);
         end
         assign row_hit[s] = (&eq) && (int'(plen) >= s + PROBE)
                             && ((int'(plen) - s) <= int'(clen));
      end else begin : g_nofit
         assign row_hit[s] = 1'b0;
      end
   end

   // lowest start wins: longest overlap
   always_comb begin
      hit   = 1'b0;
      start = '0;
      for (int s = MAX_LEN - 1; s >= 0; s--) begin
         if (row_hit[s]) begin
            hit   = 1'b1;
            start = LEN_W'(s);
         end
      end
   end
endmodule

// File: rtl/rvc_vote.sv
// Per-position majority over covering reads, ties to the earliest read.
module rvc_vote import rvc_pkg::*; #(
   parameter int N     = 8,
   parameter int CNT_W = 4
) (
   input  rvc_sym_t       tap [N],
   input  logic [N-1:0]   cov,
   output rvc_sym_t       win
);
   logic [CNT_W-1:0] cnt [N];

   for (genvar r = 0; r < N; r++) begin : g_cnt
      logic [CNT_W-1:0] c;
      always_comb begin
         c = '0;
         for (int q = 0; q < N; q++) begin
            if (cov[q] && (tap[q] == tap[r])) c = c + 1'b1;
         end
      end
      assign cnt[r] = c;
   end

   always_comb begin
      logic [CNT_W-1:0] best;
      best = '0;
      win  = '0;
      for (int r = 0; r < N; r++) begin
         if (cov[r] && (cnt[r] > best)) begin
            best = cnt[r];
            win  = tap[r];
         end
      end
   end
endmodule

// File: rtl/rvc_top.sv
module rvc_top import rvc_pkg::*; #(
   parameter int MAX_LEN   = 30,
   parameter int MAX_READS = 8,
   parameter int PROBE     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [RVC_SYM_W-1:0] in_sym,
   input  logic                 in_eor,
   input  logic                 in_eog,
   output logic                 out_valid,
   output logic [RVC_SYM_W-1:0] out_sym,
   output logic                 out_last
);
   localparam int LEN_W = $clog2(MAX_LEN + 1);
   localparam int IDX_W = $clog2(MAX_LEN);
   localparam int RD_W  = $clog2(MAX_READS + 1);
   localparam int RIX_W = $clog2(MAX_READS);
   localparam int POS_W = $clog2(MAX_READS * MAX_LEN + 1);

   if (MAX_READS < 2) begin : g_bad_reads
      $error("rvc_top: MAX_READS must be at least 2");
   end
   if (MAX_LEN < 2) begin : g_bad_len
      $error("rvc_top: MAX_LEN must be at least 2");
   end
   if ((PROBE < 1) || (PROBE > MAX_LEN)) begin : g_bad_probe
      $error("rvc_top: PROBE must lie in 1..MAX_LEN");
   end

   rvc_state_e       st;
   rvc_sym_t         mem  [MAX_READS][MAX_LEN];
   logic [LEN_W-1:0] rlen [MAX_READS];
   logic [POS_W-1:0] roff [MAX_READS];
   logic [RD_W-1:0]  nrd, kidx;
   logic [LEN_W-1:0] wpos;
   logic [POS_W-1:0] pos, total;

   // ---------------- load ----------------
   logic             rd_room, sym_room, wr_en;
   logic [RIX_W-1:0] wr_rd;
   logic [IDX_W-1:0] wr_ix;
   assign rd_room  = (nrd < RD_W'(MAX_READS));
   assign sym_room = (wpos < LEN_W'(MAX_LEN));
   assign wr_en    = (st == ST_LOAD) && in_valid && rd_room && sym_room;
   assign wr_rd    = nrd[RIX_W-1:0];
   assign wr_ix    = wpos[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_rd][wr_ix] <= in_sym;
   end

   // ---------------- align ----------------
   logic [RIX_W-1:0] kc, kp, nl;
   assign kc = kidx[RIX_W-1:0];
   assign kp = kc - 1'b1;
   assign nl = nrd[RIX_W-1:0] - 1'b1;

   rvc_sym_t         prev_row [MAX_LEN];
   rvc_sym_t         probe    [PROBE];
   logic             m_hit;
   logic [LEN_W-1:0] m_start, shift;

   always_comb begin
      for (int i = 0; i < MAX_LEN; i++) prev_row[i] = mem[kp][i];
      for (int j = 0; j < PROBE; j++)   probe[j]    = mem[kc][j];
   end

   rvc_match #(.MAX_LEN(MAX_LEN), .PROBE(PROBE), .LEN_W(LEN_W)) u_match (
      .row_src (prev_row),
      .probe   (probe),
      .plen    (rlen[kp]),
      .clen    (rlen[kc]),
      .hit     (m_hit),
      .start   (m_start)
   );
   assign shift = m_hit ? m_start : rlen[kp];

   // ---------------- vote ----------------
   rvc_sym_t             tap [MAX_READS];
   logic [MAX_READS-1:0] cov;
   rvc_sym_t             win;

   for (genvar r = 0; r < MAX_READS; r++) begin : g_tap
      logic [POS_W-1:0] rel;
      assign rel    = pos - roff[r];
      assign cov[r] = (RD_W'(r) < nrd) && (pos >= roff[r]) && (rel < POS_W'(rlen[r]));
      assign tap[r] = cov[r] ? mem[r][rel[IDX_W-1:0]] : '0;
   end

   rvc_vote #(.N(MAX_READS), .CNT_W(RD_W)) u_vote (
      .tap (tap),
      .cov (cov),
      .win (win)
   );

   // ---------------- control ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_LOAD;
         nrd   <= '0;
         kidx  <= '0;
         wpos  <= '0;
         pos   <= '0;
         total <= '0;
         for (int i = 0; i < MAX_READS; i++) begin
            rlen[i] <= '0;
            roff[i] <= '0;
         end
      end else begin
         case (st)
            ST_LOAD: begin
               if (in_valid) begin
                  if (sym_room) wpos <= wpos + 1'b1;
                  if (in_eor) begin
                     wpos <= '0;
                     if (rd_room) begin
                        rlen[wr_rd] <= wpos + LEN_W'(sym_room);
                        nrd         <= nrd + 1'b1;
                     end
                     if (in_eog) begin
                        st      <= ST_ALIGN;
                        kidx    <= RD_W'(1);
                        roff[0] <= '0;
                     end
                  end
               end
            end
            ST_ALIGN: begin
               if (kidx < nrd) begin
                  roff[kc] <= roff[kp] + POS_W'(shift);
                  kidx     <= kidx + 1'b1;
               end else begin
                  total <= roff[nl] + POS_W'(rlen[nl]);
                  pos   <= '0;
                  st    <= ST_EMIT;
               end
            end
            ST_EMIT: begin
               if (pos == total - 1'b1) begin
                  st   <= ST_LOAD;
                  nrd  <= '0;
                  wpos <= '0;
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            default: st <= ST_LOAD;
         endcase
      end
   end

   assign out_valid = (st == ST_EMIT);
   assign out_sym   = win;
   assign out_last  = out_valid && (pos == total - 1'b1);
endmodule

// File: rtl/rvc_chk.sv
module rvc_chk #(
   parameter int MAX_READS = 8,
   parameter int RD_W      = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            out_valid,
   input logic [2:0]      out_sym,
   input logic            out_last,
   input logic [RD_W-1:0] nrd
);
   // R5: the consensus stream has no holes before its final base
   p_stream_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   // R10: after the final base the output idles at least until a group reloads
   p_idle_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> (!out_valid ##1 !out_valid));

   // R8: the read count never passes the group capacity
   p_reads_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nrd <= RD_W'(MAX_READS));

   // R1: every emitted code is a defined 3-bit value
   p_sym_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$isunknown(out_sym));

   // R11: leaving reset, the output starts idle
   p_reset_idle_r11: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

bind rvc_top rvc_chk #(.MAX_READS(MAX_READS), .RD_W(RD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_sym   (out_sym),
   .out_last  (out_last),
   .nrd       (nrd)
);

// File: tb/tb_rvc_top.sv
module tb_rvc_top;
   localparam int ML = 30;
   localparam int MR = 8;
   localparam int PR = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] in_sym = '0;
   logic       in_eor = 1'b0;
   logic       in_eog = 1'b0;
   logic       out_valid;
   logic [2:0] out_sym;
   logic       out_last;

   always #5 clk = ~clk;

   rvc_top dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
      .in_eor(in_eor), .in_eog(in_eog), .out_valid(out_valid),
      .out_sym(out_sym), .out_last(out_last)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit inject = 1'b0;
   int seq     [300];
   int g_sym   [9][40];
   int g_len   [9];
   int exp_sym [300];
   int exp_n;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic set_read(input int r, input int st, input int len);
      g_len[r] = len;
      for (int i = 0; i < len; i++) g_sym[r][i] = seq[st + i];
   endtask

   // reference from R3, R4, R5, R6, R7, R8, R9
   task automatic model(input int n);
      int en;
      int el  [MR];
      int off [MR];
      en = (n > MR) ? MR : n;
      for (int r = 0; r < en; r++) el[r] = (g_len[r] > ML) ? ML : g_len[r];
      off[0] = 0;
      for (int k = 1; k < en; k++) begin
         int sh;
         sh = el[k-1];
         for (int s = el[k-1] - 1; s >= 0; s--) begin
            if ((s + PR <= el[k-1]) && (el[k-1] - s <= el[k])) begin
               bit m;
               m = 1'b1;
               for (int j = 0; j < PR; j++)
                  if (g_sym[k-1][s+j] != g_sym[k][j]) m = 1'b0;
               if (m) sh = s;
            end
         end
         off[k] = off[k-1] + sh;
      end
      exp_n = off[en-1] + el[en-1];
      for (int p = 0; p < exp_n; p++) begin
         int best;
         int w;
         best = 0;
         w = 0;
         for (int r = 0; r < en; r++) begin
            if (p >= off[r] && p < off[r] + el[r]) begin
               int c;
               c = 0;
               for (int q = 0; q < en; q++)
                  if (p >= off[q] && p < off[q] + el[q] &&
                      g_sym[q][p-off[q]] == g_sym[r][p-off[r]]) c++;
               if (c > best) begin
                  best = c;
                  w = g_sym[r][p-off[r]];
               end
            end
         end
         exp_sym[p] = w;
      end
   endtask

   task automatic send_group(input int n);
      for (int r = 0; r < n; r++) begin
         for (int i = 0; i < g_len[r]; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sym   = 3'(g_sym[r][i]);
            in_eor   = (i == g_len[r] - 1);
            in_eog   = (i == g_len[r] - 1) && (r == n - 1);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_eor   = 1'b0;
      in_eog   = 1'b0;
   endtask

   task automatic collect(input string tag);
      int cnt;
      int t;
      bit fin;
      cnt = 0;
      t = 0;
      fin = 1'b0;
      while (!fin && t < 3000) begin
         @(negedge clk);
         t++;
         if (inject) begin
            in_valid = 1'b1;
            in_sym   = 3'(t);
            in_eor   = 1'b1;
            in_eog   = 1'b1;
         end
         if (out_valid) begin
            if (cnt < exp_n)
               check(out_sym == 3'(exp_sym[cnt]), tag, $sformatf("base %0d", cnt),
                     int'(out_sym), exp_sym[cnt]);
            cnt++;
            if (out_last) fin = 1'b1;
         end
      end
      in_valid = 1'b0;
      in_eor   = 1'b0;
      in_eog   = 1'b0;
      check(fin && cnt == exp_n, "R5", "consensus length", cnt, exp_n);
   endtask

   task automatic run(input int n, input string tag);
      model(n);
      send_group(n);
      collect(tag);
   endtask

   initial begin
      int unsigned x;
      x = 32'h0000_1234;
      for (int i = 0; i < 300; i++) begin
         x = x * 32'd1664525 + 32'd1013904223;
         seq[i] = int'((x >> 13) & 32'd7);
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
      check(out_last == 1'b0, "R11", "out_last after reset", int'(out_last), 0);

      // R1: a single read walking all eight codes
      g_len[0] = 16;
      for (int i = 0; i < 16; i++) g_sym[0][i] = (i * 5) % 8;
      run(1, "R1");

      // R12: single read passes through unchanged
      set_read(0, 40, 10);
      run(1, "R12");

      // R2: reads of unequal length
      set_read(0, 60, 25);
      set_read(1, 70, 10);
      run(2, "R2");

      // R3: overlap of five, then the minimum of three
      set_read(0, 0, 10);
      set_read(1, 5, 10);
      run(2, "R3");
      set_read(0, 20, 10);
      set_read(1, 27, 10);
      run(2, "R3");

      // R4: codes that cannot match, appended with no overlap
      g_len[0] = 10;
      g_len[1] = 10;
      for (int i = 0; i < 10; i++) begin
         g_sym[0][i] = i % 2;
         g_sym[1][i] = 4 + (i % 2);
      end
      run(2, "R4");

      // R7: tie after the probe region goes to the earlier read
      g_len[0] = 10;
      g_len[1] = 11;
      for (int i = 0; i < 10; i++) g_sym[0][i] = i % 8;
      for (int i = 0; i < 11; i++) g_sym[1][i] = (i < 3) ? 5 + i : 3;
      run(2, "R7");

      // R6: a third read outvotes the first
      g_len[2] = 11;
      for (int i = 0; i < 11; i++) g_sym[2][i] = g_sym[1][i];
      run(3, "R6");

      // R9: over-long read is cut to 30 symbols
      set_read(0, 100, 33);
      run(1, "R9");

      // R8: a ninth read is dropped, and the next group is clean
      for (int r = 0; r < 9; r++) set_read(r, 150 + r * 2, 10);
      run(9, "R8");
      set_read(0, 200, 12);
      set_read(1, 204, 12);
      run(2, "R8");

      // R6 sweep: read count x stride x substitution
      for (int n = 1; n <= MR; n++) begin
         for (int st = 1; st <= 9; st++) begin
            for (int nz = 0; nz < 2; nz++) begin
               for (int r = 0; r < n; r++) begin
                  set_read(r, r * st, 12);
                  if (nz == 1) begin
                     int ix;
                     ix = (r * 3 + 4) % 12;
                     g_sym[r][ix] = (g_sym[r][ix] + 1) % 8;
                  end
               end
               run(n, "R6");
            end
         end
      end

      // R10: load-port traffic during align and emit is ignored
      for (int r = 0; r < 3; r++) set_read(r, 220 + r * 4, 12);
      inject = 1'b1;
      run(3, "R10");
      inject = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R10", "idle after injected group", int'(out_valid), 0);
      end
      set_read(0, 250, 11);
      set_read(1, 256, 11);
      run(2, "R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R5 watchdog expired: actual 0 expected 1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule